// File: doc/BRIEF.md
# Chained Vector Execution Sequencer

The sequencer owns eight vector registers of 64 elements, each element 64 bits wide. It also holds a length register, which sets how many leading elements an operation touches, and a 64-bit mask. Vector instructions arrive one at a time on a valid/ready port. Each instruction goes to one of two fully pipelined integer units. The multiply unit has a latency of `MUL_LAT`. The add unit has a latency of `ADD_LAT` and also runs the zero test and the masked merge. Each unit works through its vector one element per cycle.

An instruction that reads a register still being produced does not wait for the whole vector. A per-register count of written elements lets it take element i as soon as element i has been written back. A multiply followed by a dependent add therefore finishes in about the vector length plus both latencies, not in twice the vector length.

Issue stalls in three cases:
- the target unit is still stepping through its elements;
- the destination is still pending from an earlier instruction;
- the destination is being read by an instruction in progress.

A load port fills elements, standing in for the memory path. A combinational read port returns any element.

Top module: `vseq_chain`

## Requirements
- R1: After reset, `busy` is 0, `in_ready` is 1, `vl_out` is 64 and `mask_out` is 0.
- R2: Opcode 0 (set length) loads the length register with `in_scalar` clamped to 64, and `vl_out` shows it from the edge that accepts it.
- R3: Opcode 1 (add) writes vd[i] = vs1[i] + vs2[i] modulo 2^64 for every i below the length. The two units never write the same register in one cycle.
- R4: Opcode 2 (multiply) writes vd[i] = low 64 bits of vs1[i] * vs2[i]. Opcode 3 (scale) writes vd[i] = low 64 bits of vs1[i] * `in_scalar`.
- R5: Opcode 4 (zero test) sets mask bit i to 1 when vs1[i] is zero and to 0 otherwise, for i below the length. Mask bits at or above the length keep their value, and the mask changes only on a test write-back.
- R6: Opcode 5 (merge) writes vd[i] = vs1[i] where mask bit i is 1 and vs2[i] where it is 0.
- R7: Elements at or above the length are never written. With length 0 an instruction is accepted and changes nothing, and `busy` stays 0.
- R8: A scale accepted on one edge, followed by a dependent add accepted on the next edge, ends with `busy` falling exactly 64 + MUL_LAT + ADD_LAT + 1 edges after the first acceptance (length 64). Every write-back targets a register marked pending.
- R9: An instruction whose destination is a source of an instruction still reading its operands is held until that reader has issued its last element. At length 64 on an otherwise idle machine it is accepted exactly 65 edges after the reader. The reader uses the old values.
- R10: An instruction for a unit that is still issuing is held: at length 64 it is accepted 65 edges after the previous instruction to that unit. A unit is never restarted while active.
- R11: A load-port write stores `ld_data` at `ld_reg`/`ld_idx`, and `rd_data` returns `vrf[rd_reg][rd_idx]` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_op | input | 3 | Opcode (0 length, 1 add, 2 mul, 3 scale, 4 test, 5 merge) |
| in_vd | input | 3 | Destination register |
| in_vs1 | input | 3 | First source register |
| in_vs2 | input | 3 | Second source register |
| in_scalar | input | 64 | Scalar operand or new length |
| ld_we | input | 1 | Element load strobe |
| ld_reg | input | 3 | Load register |
| ld_idx | input | 6 | Load element index |
| ld_data | input | 64 | Load data |
| rd_reg | input | 3 | Read register |
| rd_idx | input | 6 | Read element index |
| rd_data | output | 64 | Read data |
| mask_out | output | 64 | Current mask |
| vl_out | output | 7 | Current length |
| busy | output | 1 | Any unit issuing or any result in flight |

## Verification
The multiply unit's write-back and the add unit's write-back land in the register file in the same cycle whenever a chained pair streams. The add unit is also reading element i of the register whose element i+1 the multiplier is writing. The bench provokes this with a scale followed on the very next edge by an add that consumes its result. It then judges every element of both destinations against its own model and checks the exact edge on which `busy` falls. A second overlap is a held writer against an active reader of the same register. That is judged by the acceptance edge and by the reader still seeing old values.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int NREG     = 8;
  localparam int NELEM    = 64;
  localparam int EW       = 64;
  localparam int REG_W    = $clog2(NREG);
  localparam int IDX_W    = $clog2(NELEM);
  localparam int VL_W     = IDX_W + 1;
  localparam int RES_W    = REG_W + 1;
  localparam int NRES     = NREG + 1;
  localparam int MASK_RES = NREG;

  typedef enum logic [2:0] {
    OP_SETVL  = 3'd0,
    OP_VADD   = 3'd1,
    OP_VMUL   = 3'd2,
    OP_VMULS  = 3'd3,
    OP_VTEST  = 3'd4,
    OP_VMERGE = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } vop_e;

  typedef struct packed {
    logic             last;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] res;
    logic [EW-1:0]    data;
  } wb_t;

  localparam int WB_W = $bits(wb_t);

  function automatic logic is_mul_op(vop_e op);
    return (op == OP_VMUL) || (op == OP_VMULS);
  endfunction

  function automatic logic is_add_op(vop_e op);
    return (op == OP_VADD) || (op == OP_VTEST) || (op == OP_VMERGE);
  endfunction

  function automatic logic uses_s2(vop_e op);
    return (op == OP_VADD) || (op == OP_VMUL) || (op == OP_VMERGE);
  endfunction

  function automatic logic [EW-1:0] elem_calc(vop_e op, logic [EW-1:0] a,
                                              logic [EW-1:0] b, logic [EW-1:0] s,
                                              logic m);
    case (op)
      OP_VADD:   return a + b;
      OP_VMUL:   return a * b;
      OP_VMULS:  return a * s;
      OP_VTEST:  return {{(EW-1){1'b0}}, (a == '0)};
      OP_VMERGE: return m ? a : b;
      default:   return '0;
    endcase
  endfunction

  function automatic logic [VL_W-1:0] clamp_vl(logic [EW-1:0] s);
    return (s > EW'(NELEM)) ? VL_W'(NELEM) : s[VL_W-1:0];
  endfunction

  // element idx of resource rs may be read now
  function automatic logic src_ready(logic en, logic [RES_W-1:0] rs,
                                     logic [RES_W-1:0] own, logic pend_bit,
                                     logic [VL_W-1:0] cnt, logic [IDX_W-1:0] idx);
    return !en || (rs == own) || !pend_bit || (cnt > {1'b0, idx});
  endfunction

  function automatic logic reads_res(logic act, logic [RES_W-1:0] rs1,
                                     logic en2, logic [RES_W-1:0] rs2,
                                     logic enm, logic [RES_W-1:0] r);
    return act && ((rs1 == r) || (en2 && rs2 == r) ||
                   (enm && r == RES_W'(MASK_RES)));
  endfunction
endpackage

// File: rtl/vseq_delay.sv
module vseq_delay #(
  parameter int LAT = 2,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d,
  output logic         any_v
);
  logic [LAT-1:0] v;
  logic [W-1:0]   d [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v[0] <= 1'b0;
      d[0] <= '0;
    end else begin
      v[0] <= in_v;
      d[0] <= in_d;
    end
  end

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v[k] <= 1'b0;
        d[k] <= '0;
      end else begin
        v[k] <= v[k-1];
        d[k] <= d[k-1];
      end
    end
  end

  assign out_v = v[LAT-1];
  assign out_d = d[LAT-1];
  assign any_v = |v;
endmodule

// File: rtl/vseq_unit.sv
module vseq_unit import vseq_pkg::*; #(
  parameter int LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  vop_e             start_op,
  input  logic [RES_W-1:0] start_dst,
  input  logic [RES_W-1:0] start_s1,
  input  logic [RES_W-1:0] start_s2,
  input  logic [EW-1:0]    start_scal,
  input  logic [VL_W-1:0]  start_vl,
  input  logic             elem_ok,
  input  logic [EW-1:0]    opa,
  input  logic [EW-1:0]    opb,
  input  logic             mbit,
  output logic             active,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [RES_W-1:0] dst,
  output logic [RES_W-1:0] rs1,
  output logic [RES_W-1:0] rs2,
  output logic             rs2_en,
  output logic             rm_en,
  output logic             wb_v,
  output wb_t              wb
);
  vop_e            op_q;
  logic [EW-1:0]   scal_q;
  logic [VL_W-1:0] vl_q;
  logic            go, last_el, pipe_busy;
  wb_t             pin;
  logic [WB_W-1:0] wb_raw;

  assign go      = active && elem_ok;
  assign last_el = ({1'b0, idx} == vl_q - 1'b1);
  assign rs2_en  = active && uses_s2(op_q);
  assign rm_en   = active && (op_q == OP_VMERGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      op_q   <= OP_SETVL;
      dst    <= '0;
      rs1    <= '0;
      rs2    <= '0;
      scal_q <= '0;
      vl_q   <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      op_q   <= start_op;
      dst    <= start_dst;
      rs1    <= start_s1;
      rs2    <= start_s2;
      scal_q <= start_scal;
      vl_q   <= start_vl;
    end else if (go) begin
      if (last_el) active <= 1'b0;
      else         idx    <= idx + 1'b1;
    end
  end

  assign pin = '{last: last_el, idx: idx, res: dst,
                 data: elem_calc(op_q, opa, opb, scal_q, mbit)};

  vseq_delay #(.LAT(LAT), .W(WB_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (go),
    .in_d  (pin),
    .out_v (wb_v),
    .out_d (wb_raw),
    .any_v (pipe_busy)
  );

  assign wb   = wb_t'(wb_raw);
  assign busy = active || pipe_busy;

  // R7
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, idx} < vl_q));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
endmodule

// File: rtl/vseq_hazard.sv
module vseq_hazard import vseq_pkg::*; (
  input  logic             in_valid,
  input  vop_e             op,
  input  logic [RES_W-1:0] dst_res,
  input  logic             vl_nz,
  input  logic [NRES-1:0]  pend,
  input  logic             m_active,
  input  logic [RES_W-1:0] m_rs1,
  input  logic [RES_W-1:0] m_rs2,
  input  logic             m_rs2_en,
  input  logic             a_active,
  input  logic [RES_W-1:0] a_rs1,
  input  logic [RES_W-1:0] a_rs2,
  input  logic             a_rs2_en,
  input  logic             a_rm_en,
  output logic             in_ready,
  output logic             start_m,
  output logic             start_a
);
  logic needs_m, needs_a, unit_busy, waw, war, blocked;

  assign needs_m   = is_mul_op(op);
  assign needs_a   = is_add_op(op);
  assign unit_busy = (needs_m && m_active) || (needs_a && a_active);
  assign waw       = pend[dst_res];
  assign war       = reads_res(m_active, m_rs1, m_rs2_en, m_rs2, 1'b0, dst_res) ||
                     reads_res(a_active, a_rs1, a_rs2_en, a_rs2, a_rm_en, dst_res);
  assign blocked   = vl_nz && (needs_m || needs_a) && (unit_busy || waw || war);
  assign in_ready  = !blocked;
  assign start_m   = in_valid && in_ready && vl_nz && needs_m;
  assign start_a   = in_valid && in_ready && vl_nz && needs_a;
endmodule

// File: rtl/vseq_chain.sv
module vseq_chain import vseq_pkg::*; #(
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [REG_W-1:0] in_vd,
  input  logic [REG_W-1:0] in_vs1,
  input  logic [REG_W-1:0] in_vs2,
  input  logic [EW-1:0]    in_scalar,
  input  logic             ld_we,
  input  logic [REG_W-1:0] ld_reg,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [EW-1:0]    ld_data,
  input  logic [REG_W-1:0] rd_reg,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [EW-1:0]    rd_data,
  output logic [NELEM-1:0] mask_out,
  output logic [VL_W-1:0]  vl_out,
  output logic             busy
);
  logic [EW-1:0]    vrf [NREG][NELEM];
  logic [NELEM-1:0] mask_r;
  logic [VL_W-1:0]  vl_r;
  logic [NRES-1:0]  pend;
  logic [VL_W-1:0]  wcnt [NRES];

  vop_e             op_in;
  logic [RES_W-1:0] dst_res, s1_res, s2_res;
  logic             start_m, start_a, accept_vl;

  logic             m_active, m_busy, m_rs2_en, m_rm_en, m_ok, m_wb_v;
  logic [IDX_W-1:0] m_idx;
  logic [RES_W-1:0] m_dst, m_rs1, m_rs2;
  logic [EW-1:0]    m_opa, m_opb;
  wb_t              m_wb;

  logic             a_active, a_busy, a_rs2_en, a_rm_en, a_ok, a_wb_v, a_mbit;
  logic [IDX_W-1:0] a_idx;
  logic [RES_W-1:0] a_dst, a_rs1, a_rs2;
  logic [EW-1:0]    a_opa, a_opb;
  wb_t              a_wb;

  assign op_in     = vop_e'(in_op);
  assign dst_res   = (op_in == OP_VTEST) ? RES_W'(MASK_RES) : {1'b0, in_vd};
  assign s1_res    = {1'b0, in_vs1};
  assign s2_res    = {1'b0, in_vs2};
  assign accept_vl = in_valid && in_ready && (op_in == OP_SETVL);

  vseq_hazard u_haz (
    .in_valid (in_valid),  .op       (op_in),    .dst_res  (dst_res),
    .vl_nz    (vl_r != '0), .pend    (pend),
    .m_active (m_active),  .m_rs1    (m_rs1),    .m_rs2    (m_rs2),
    .m_rs2_en (m_rs2_en),  .a_active (a_active), .a_rs1    (a_rs1),
    .a_rs2    (a_rs2),     .a_rs2_en (a_rs2_en), .a_rm_en  (a_rm_en),
    .in_ready (in_ready),  .start_m  (start_m),  .start_a  (start_a)
  );

  // operand fetch and chaining gate, multiply unit
  assign m_opa = vrf[m_rs1[REG_W-1:0]][m_idx];
  assign m_opb = vrf[m_rs2[REG_W-1:0]][m_idx];
  assign m_ok  = src_ready(1'b1, m_rs1, m_dst, pend[m_rs1], wcnt[m_rs1], m_idx) &&
                 src_ready(m_rs2_en, m_rs2, m_dst, pend[m_rs2], wcnt[m_rs2], m_idx);

  // operand fetch and chaining gate, add unit (mask is resource MASK_RES)
  assign a_opa  = vrf[a_rs1[REG_W-1:0]][a_idx];
  assign a_opb  = vrf[a_rs2[REG_W-1:0]][a_idx];
  assign a_mbit = mask_r[a_idx];
  assign a_ok   = src_ready(1'b1, a_rs1, a_dst, pend[a_rs1], wcnt[a_rs1], a_idx) &&
                  src_ready(a_rs2_en, a_rs2, a_dst, pend[a_rs2], wcnt[a_rs2], a_idx) &&
                  src_ready(a_rm_en, RES_W'(MASK_RES), a_dst, pend[MASK_RES],
                            wcnt[MASK_RES], a_idx);

  vseq_unit #(.LAT(MUL_LAT)) u_mul (
    .clk (clk), .rst_n (rst_n), .start (start_m), .start_op (op_in),
    .start_dst (dst_res), .start_s1 (s1_res), .start_s2 (s2_res),
    .start_scal (in_scalar), .start_vl (vl_r), .elem_ok (m_ok),
    .opa (m_opa), .opb (m_opb), .mbit (1'b0),
    .active (m_active), .busy (m_busy), .idx (m_idx), .dst (m_dst),
    .rs1 (m_rs1), .rs2 (m_rs2), .rs2_en (m_rs2_en), .rm_en (m_rm_en),
    .wb_v (m_wb_v), .wb (m_wb)
  );

  vseq_unit #(.LAT(ADD_LAT)) u_add (
    .clk (clk), .rst_n (rst_n), .start (start_a), .start_op (op_in),
    .start_dst (dst_res), .start_s1 (s1_res), .start_s2 (s2_res),
    .start_scal (in_scalar), .start_vl (vl_r), .elem_ok (a_ok),
    .opa (a_opa), .opb (a_opb), .mbit (a_mbit),
    .active (a_active), .busy (a_busy), .idx (a_idx), .dst (a_dst),
    .rs1 (a_rs1), .rs2 (a_rs2), .rs2_en (a_rs2_en), .rm_en (a_rm_en),
    .wb_v (a_wb_v), .wb (a_wb)
  );

  // register file: load port plus one write-back per unit
  always_ff @(posedge clk) begin
    if (ld_we) vrf[ld_reg][ld_idx] <= ld_data;
    if (m_wb_v && !m_wb.res[REG_W]) vrf[m_wb.res[REG_W-1:0]][m_wb.idx] <= m_wb.data;
    if (a_wb_v && !a_wb.res[REG_W]) vrf[a_wb.res[REG_W-1:0]][a_wb.idx] <= a_wb.data;
  end

  // pending flags and written-element counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      for (int r = 0; r < NRES; r++) wcnt[r] <= '0;
    end else begin
      for (int r = 0; r < NRES; r++) begin
        if ((start_m || start_a) && dst_res == RES_W'(r)) begin
          pend[r] <= 1'b1;
          wcnt[r] <= '0;
        end else if (m_wb_v && m_wb.res == RES_W'(r)) begin
          wcnt[r] <= wcnt[r] + 1'b1;
          if (m_wb.last) pend[r] <= 1'b0;
        end else if (a_wb_v && a_wb.res == RES_W'(r)) begin
          wcnt[r] <= wcnt[r] + 1'b1;
          if (a_wb.last) pend[r] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r <= '0;
      vl_r   <= VL_W'(NELEM);
    end else begin
      if (a_wb_v && a_wb.res == RES_W'(MASK_RES)) mask_r[a_wb.idx] <= a_wb.data[0];
      if (accept_vl) vl_r <= clamp_vl(in_scalar);
    end
  end

  assign rd_data  = vrf[rd_reg][rd_idx];
  assign mask_out = mask_r;
  assign vl_out   = vl_r;
  assign busy     = m_busy || a_busy;

  // R8
  mul_wb_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wb_v |-> pend[m_wb.res]);

  // R8
  add_wb_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_wb_v |-> pend[a_wb.res]);

  // R3
  wb_no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wb_v && a_wb_v) |-> (m_wb.res != a_wb.res));

  // R2
  vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_r <= VL_W'(NELEM));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_wb_v && a_wb.res == RES_W'(MASK_RES)) |=> $stable(mask_r));
endmodule

// File: tb/vseq_chain_test.sv
module vseq_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int ML = 3;
  localparam int AL = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [2:0]  in_op = '0, in_vd = '0, in_vs1 = '0, in_vs2 = '0;
  logic [63:0] in_scalar = '0;
  logic        ld_we = 1'b0;
  logic [2:0]  ld_reg = '0, rd_reg = '0;
  logic [5:0]  ld_idx = '0, rd_idx = '0;
  logic [63:0] ld_data = '0, rd_data, mask_out;
  logic [6:0]  vl_out;
  logic        busy;

  vseq_chain #(.MUL_LAT(ML), .ADD_LAT(AL)) uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_op (in_op), .in_vd (in_vd), .in_vs1 (in_vs1), .in_vs2 (in_vs2),
    .in_scalar (in_scalar), .ld_we (ld_we), .ld_reg (ld_reg), .ld_idx (ld_idx),
    .ld_data (ld_data), .rd_reg (rd_reg), .rd_idx (rd_idx), .rd_data (rd_data),
    .mask_out (mask_out), .vl_out (vl_out), .busy (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [63:0] mdl [8][64];
  logic [63:0] mmask = '0;
  int          mvl = 64;

  typedef struct { int r; int i; logic [63:0] v; string req; } exp_t;
  exp_t q[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(int r, int i);
    if (r == 3 && i % 3 == 0) return 64'd0;
    return (64'(r + 1) << 56) ^ (64'(i) * 64'h9E3779B97F4A7C15) ^ 64'(i * 7 + r);
  endfunction

  // driver: loads one element, records it for the monitor
  task automatic load(int r, int i, logic [63:0] d);
    ld_we = 1'b1; ld_reg = 3'(r); ld_idx = 6'(i); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
    mdl[r][i] = d;
  endtask

  task automatic push_reg(int r, string req);
    for (int i = 0; i < 64; i++) q.push_back('{r, i, mdl[r][i], req});
  endtask

  // driver: issues one instruction, updates the model, pushes expectations
  task automatic issue(int op, int vd, int vs1, int vs2, logic [63:0] sc,
                       string req, output int acc);
    in_op = 3'(op); in_vd = 3'(vd); in_vs1 = 3'(vs1); in_vs2 = 3'(vs2);
    in_scalar = sc; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    acc = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < mvl; i++) begin
      case (op)
        1: mdl[vd][i] = mdl[vs1][i] + mdl[vs2][i];
        2: mdl[vd][i] = mdl[vs1][i] * mdl[vs2][i];
        3: mdl[vd][i] = mdl[vs1][i] * sc;
        4: mmask[i]   = (mdl[vs1][i] == 64'd0);
        5: mdl[vd][i] = mmask[i] ? mdl[vs1][i] : mdl[vs2][i];
        default: ;
      endcase
    end
    if (op == 0) mvl = (sc > 64) ? 64 : int'(sc);
    if (op >= 1 && op <= 3 || op == 5) push_reg(vd, req);
  endtask

  task automatic wait_idle();
    #1;
    while (busy) begin @(negedge clk); #1; end
  endtask

  // monitor: pops expectations and compares through the read port
  task automatic drain();
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      rd_reg = 3'(e.r); rd_idx = 6'(e.i);
      #1;
      chk(e.req, rd_data, e.v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a0, a1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 vl_out", 64'(vl_out), 64'd64);
    chk("R1 mask_out", mask_out, 64'd0);
    @(negedge clk);

    // R11 load port and read port
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) load(r, i, pat(r, i));
    push_reg(0, "R11"); push_reg(3, "R11");
    drain();

    // R8 chained scale then add, both streaming (R3, R4 values)
    issue(3, 2, 3, 0, 64'd7, "R4 scale", a0);
    issue(1, 4, 2, 1, 64'd0, "R3 add chained", a1);
    chk("R8 add accepted next edge", 64'(a1 - a0), 64'd1);
    wait_idle();
    chk("R8 busy falls", 64'(cyc - a0), 64'(64 + ML + AL + 1));
    drain();

    // R10 structural hold on multiply unit (R4 vector multiply)
    issue(2, 5, 6, 7, 64'd0, "R4 mul", a0);
    issue(3, 0, 1, 0, 64'd5, "R10 scale", a1);
    chk("R10 held until unit free", 64'(a1 - a0), 64'd65);
    wait_idle();
    drain();

    // R9 write-after-read hold; reader keeps old values of v6
    issue(2, 5, 6, 7, 64'd0, "R9 reader", a0);
    issue(1, 6, 0, 1, 64'd0, "R9 writer", a1);
    chk("R9 held until reads done", 64'(a1 - a0), 64'd65);
    wait_idle();
    drain();

    // R5 zero test, R6 merge
    issue(4, 0, 3, 0, 64'd0, "R5", a0);
    wait_idle();
    chk("R5 mask", mask_out, mmask);
    issue(5, 7, 0, 1, 64'd0, "R6 merge", a0);
    wait_idle();
    drain();

    // R2 length, R7 partial length, R5 upper mask bits held
    issue(0, 0, 0, 0, 64'd5, "R2", a0);
    chk("R2 vl 5", 64'(vl_out), 64'd5);
    issue(1, 2, 0, 1, 64'd0, "R7 partial", a0);
    issue(4, 0, 4, 0, 64'd0, "R5", a0);
    wait_idle();
    chk("R5 mask partial", mask_out, mmask);
    drain();
    issue(0, 0, 0, 0, 64'd200, "R2", a0);
    chk("R2 vl clamp", 64'(vl_out), 64'd64);
    issue(0, 0, 0, 0, 64'd0, "R2", a0);
    chk("R2 vl 0", 64'(vl_out), 64'd0);
    issue(1, 0, 1, 2, 64'd0, "R7 zero length", a0);
    #1;
    chk("R7 busy zero length", 64'(busy), 64'd0);
    wait_idle();
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule